// File: doc/BRIEF.md
# Serial Readout Port for a Delta-Sigma Converter

This block is the digital side of the serial interface of a multiplexed delta-sigma converter that runs in external-clock, single-cycle mode. A host lowers the select line, toggles the serial clock, reads a 24-bit frame on the data output and shifts an 8-bit configuration in on the data input. The block also owns the conversion sequence. An internal timer stands in for the modulator. When the timer expires, the result word is latched from a parallel input port and the block goes to sleep until the host reads the result.

All three host lines are synchronized to the system clock with two-flop synchronizers, and their edges are detected on the synchronized copies. The serial clock must therefore run well below the system clock. A serial clock at 1/12 of the system clock or slower is comfortable. The serial output is given as a value plus an output enable, so a pad cell can build the tri-state driver. The level of the serial clock at each select falling edge picks the mode. The internal-clock mode is only detected and flagged; while it is flagged, the port ignores the serial clock.

The FSM has three states. `ST_CONVERT`: the timer is running and the output shows busy. `ST_SLEEP`: the result is held and the output shows ready. `ST_SHIFT`: a data cycle is in progress. The transitions are:
- CONVERT→SLEEP when the timer expires.
- SLEEP→SHIFT on a serial clock rising edge while selected in external mode.
- SHIFT→CONVERT on the 24th falling edge.
- SHIFT→SLEEP when select rises early.

Top module: `convport_slave`

## Requirements
- R1: On every falling edge of `sel_n`, and once just after reset, `int_mode` takes the level of `ser_clk`. High flags internal-clock mode and low selects external-clock mode.
- R2: `ser_oe` is 0 whenever `sel_n` has been high for 3 system clocks, and it is 1 whenever `sel_n` has been low for 3 system clocks.
- R3: With the port selected and no data cycle begun, `ser_out` is 1 while a conversion runs and 0 once the device is asleep with a result ready.
- R4: A conversion lasts `CONV_CYCLES` system clocks. At its end, `result_in` is latched into the frame and the device falls asleep whatever the level of `sel_n`. Reset starts a conversion.
- R5: While asleep, the device stays asleep indefinitely until the first `ser_clk` rising edge seen with `sel_n` low. Edges seen with `sel_n` high do not wake it.
- R6: The frame has 24 bits, sent most significant first. Bit 23 is the busy flag (0). Bits 22..16 are the header `HEADER` (default 7'h65). Bits 15..0 are the result, MSB first. Frame bit 23-k is on `ser_out` after the k-th `ser_clk` falling edge of the cycle.
- R7: `ser_in` is sampled on the first 8 `ser_clk` rising edges of a data cycle, the first bit becoming the MSB. This byte appears on `conv_cfg` when the next conversion starts.
- R8: The 24th `ser_clk` falling edge gives a one-system-clock pulse on `conv_start`, starts a conversion, and drives `ser_out` to 1.
- R9: If `sel_n` rises before the 24th falling edge, the cycle is abandoned. There is no `conv_start` pulse and `conv_cfg` is unchanged. The next cycle starts again at frame bit 23 with the same held result.
- R10: While `int_mode` is 1, `ser_clk` edges neither wake the device nor start a conversion.
- R11: During reset, `ser_oe`, `conv_start`, `int_mode` and `conv_cfg` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Host select, active low |
| ser_clk | input | 1 | Host serial clock |
| ser_in | input | 1 | Host serial data into the port |
| result_in | input | DATA_BITS | Conversion result, latched when a conversion ends |
| ser_out | output | 1 | Serial data / busy flag value |
| ser_oe | output | 1 | Output enable for `ser_out` |
| conv_start | output | 1 | One-cycle pulse when a conversion begins |
| conv_cfg | output | CFG_BITS | Configuration in force for the running conversion |
| int_mode | output | 1 | Internal-clock mode detected |

## Verification
A table of result/configuration pairs drives full read cycles. The pairs are a mixed pattern, a lone low bit with a high nibble of configuration, all ones with a zero configuration, and a lone MSB. Together they show whether the frame ordering, the header placement and the MSB-first sampling of `ser_in` are right, and whether any bit is stuck. Directed tests cover the following:
- the power-up busy flag;
- a cycle abandoned after 10 clocks, which must not reload the result or apply the configuration;
- serial clock edges with select high, and a long idle with select low, neither of which may wake the device;
- a detour into internal-clock mode, which must leave the held frame intact.

// File: rtl/convport_pkg.sv
package convport_pkg;
    // Length of one serial data cycle; the start of conversion is tied to it.
    localparam int FRAME_BITS = 24;

    typedef enum logic [1:0] {
        ST_CONVERT,
        ST_SLEEP,
        ST_SHIFT
    } port_state_e;
endpackage

// File: rtl/convport_sync.sv
module convport_sync #(
    parameter int              WIDTH   = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/convport_timer.sv
module convport_timer #(
    parameter int CONV_CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int CW = $clog2(CONV_CYCLES + 1);

    logic [CW-1:0] remain_q;

    // Reset loads the counter, so a power-up conversion runs at once.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= CW'(CONV_CYCLES);
        end else if (start) begin
            remain_q <= CW'(CONV_CYCLES);
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign done = (remain_q == CW'(1));
endmodule

// File: rtl/convport_slave.sv
module convport_slave
    import convport_pkg::*;
#(
    parameter int DATA_BITS   = 16,
    parameter int CFG_BITS    = 8,
    parameter int CONV_CYCLES = 40,
    parameter int HEADER      = 'h65
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel_n,
    input  logic                 ser_clk,
    input  logic                 ser_in,
    input  logic [DATA_BITS-1:0] result_in,
    output logic                 ser_out,
    output logic                 ser_oe,
    output logic                 conv_start,
    output logic [CFG_BITS-1:0]  conv_cfg,
    output logic                 int_mode
);
    localparam int                HDR_W = FRAME_BITS - 1 - DATA_BITS;
    localparam int                CNT_W = $clog2(FRAME_BITS);
    localparam int                RC_W  = $clog2(CFG_BITS + 1);
    localparam logic [HDR_W-1:0]  HDR_V = HDR_W'(HEADER);

    // Synchronized host lines
    logic [2:0] sync_q;
    logic       sel_s, sck_s, sdi_s;
    logic       sel_d, sck_d;
    logic       sel_fall, sck_rise, sck_fall;
    logic [1:0] pu_cnt;

    // FSM and datapath
    port_state_e           state, nxt;
    logic                  conv_done;
    logic                  frame_end;
    logic [CNT_W-1:0]      fall_cnt;
    logic [RC_W-1:0]       rise_cnt;
    logic [CFG_BITS-1:0]   cfg_shift;
    logic [FRAME_BITS-1:0] frame_q;

    convport_sync #(
        .WIDTH  (3),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({sel_n, ser_clk, ser_in}),
        .q    (sync_q)
    );

    assign sel_s = sync_q[2];
    assign sck_s = sync_q[1];
    assign sdi_s = sync_q[0];

    assign sel_fall = sel_d & ~sel_s;
    assign sck_rise = ~sck_d & sck_s;
    assign sck_fall = sck_d & ~sck_s;

    convport_timer #(
        .CONV_CYCLES(CONV_CYCLES)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .start(conv_start),
        .done (conv_done)
    );

    assign frame_end = sck_fall && (fall_cnt == CNT_W'(FRAME_BITS - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_CONVERT;
        else        state <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_CONVERT: if (conv_done) nxt = ST_SLEEP;
            ST_SLEEP:   if (!sel_s && !int_mode && sck_rise) nxt = ST_SHIFT;
            ST_SHIFT: begin
                if (sel_s)          nxt = ST_SLEEP;
                else if (frame_end) nxt = ST_CONVERT;
            end
            default:    nxt = ST_CONVERT;
        endcase
    end

    // Outputs
    always_comb begin
        ser_oe     = ~sel_s;
        conv_start = 1'b0;
        ser_out    = 1'b1;
        unique case (state)
            ST_CONVERT: ser_out = 1'b1;
            ST_SLEEP:   ser_out = 1'b0;
            ST_SHIFT: begin
                ser_out    = frame_q[CNT_W'(FRAME_BITS - 1) - fall_cnt];
                conv_start = !sel_s && frame_end;
            end
            default:    ser_out = 1'b1;
        endcase
    end

    // Edge history and mode detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_d    <= 1'b1;
            sck_d    <= 1'b0;
            pu_cnt   <= '0;
            int_mode <= 1'b0;
        end else begin
            sel_d <= sel_s;
            sck_d <= sck_s;
            if (pu_cnt != 2'd3) pu_cnt <= pu_cnt + 1'b1;
            if (pu_cnt == 2'd2 || sel_fall) int_mode <= sck_s;
        end
    end

    // Result frame, bit counters, configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q   <= '0;
            fall_cnt  <= '0;
            rise_cnt  <= '0;
            cfg_shift <= '0;
            conv_cfg  <= '0;
        end else begin
            if (state == ST_CONVERT && conv_done) begin
                frame_q <= {1'b0, HDR_V, result_in};
            end
            if (state == ST_SLEEP && nxt == ST_SHIFT) begin
                fall_cnt  <= '0;
                rise_cnt  <= RC_W'(1);
                cfg_shift <= CFG_BITS'(sdi_s);
            end else if (state == ST_SHIFT) begin
                if (sel_s) begin
                    fall_cnt <= '0;
                    rise_cnt <= '0;
                end else begin
                    if (sck_rise && rise_cnt < RC_W'(CFG_BITS)) begin
                        cfg_shift <= {cfg_shift[CFG_BITS-2:0], sdi_s};
                        rise_cnt  <= rise_cnt + 1'b1;
                    end
                    if (frame_end) begin
                        fall_cnt <= '0;
                        rise_cnt <= '0;
                        conv_cfg <= cfg_shift;
                    end else if (sck_fall) begin
                        fall_cnt <= fall_cnt + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/convport_chk.sv
module convport_chk #(
    parameter int CFG_BITS = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sel_n,
    input logic                ser_out,
    input logic                ser_oe,
    input logic                conv_start,
    input logic [CFG_BITS-1:0] conv_cfg,
    input logic                int_mode
);
    // R2
    oe_off_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n && $past(sel_n) && $past(sel_n, 2) && $past(sel_n, 3)) |-> !ser_oe);

    // R8
    start_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R8
    busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> ser_out);

    // R7
    cfg_moves_only_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(conv_cfg) |-> $past(conv_start));

    // R10
    no_start_in_internal_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_mode |-> !conv_start);
endmodule

bind convport_slave convport_chk #(
    .CFG_BITS(CFG_BITS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_n     (sel_n),
    .ser_out   (ser_out),
    .ser_oe    (ser_oe),
    .conv_start(conv_start),
    .conv_cfg  (conv_cfg),
    .int_mode  (int_mode)
);

// File: tb/convport_slave_test.sv
module convport_slave_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1;
    logic        ser_clk = 1'b0;
    logic        ser_in = 1'b0;
    logic [15:0] result_in = '0;
    logic        ser_out, ser_oe, conv_start, int_mode;
    logic [7:0]  conv_cfg;

    int checks = 0;
    int fails  = 0;
    int starts = 0;

    // {result, configuration}
    localparam logic [23:0] VECS [4] = '{
        24'hA5C3_3C, 24'hFFFE_F0, 24'hFFFF_00, 24'h8000_A7
    };

    convport_slave uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_n     (sel_n),
        .ser_clk   (ser_clk),
        .ser_in    (ser_in),
        .result_in (result_in),
        .ser_out   (ser_out),
        .ser_oe    (ser_oe),
        .conv_start(conv_start),
        .conv_cfg  (conv_cfg),
        .int_mode  (int_mode)
    );

    always #4 clk = ~clk;

    always @(posedge clk) if (rst_n && conv_start) starts++;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic sck_cycle(input logic d);
        ser_in = d;
        wclk(2);
        ser_clk = 1'b1;
        wclk(6);
        ser_clk = 1'b0;
        wclk(6);
    endtask

    // R6 R7 R8: full read of one frame while shifting a configuration in
    task automatic read_frame(input logic [15:0] res, input logic [7:0] cfg);
        logic [23:0] f;
        int s0;
        f  = {1'b0, 7'h65, res};
        s0 = starts;
        for (int i = 0; i < 24; i++) begin
            chk(ser_out == f[23-i], $sformatf("R6 frame bit %0d", 23 - i), ser_out, f[23-i]);
            sck_cycle(i < 8 ? cfg[7-i] : 1'b0);
        end
        chk(starts == s0 + 1, "R8 start pulse count", starts, s0 + 1);
        chk(ser_out == 1'b1, "R8 busy after 24th fall", ser_out, 1);
        chk(conv_cfg == cfg, "R7 configuration applied", conv_cfg, cfg);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int s0;
        result_in = VECS[0][23:8];
        wclk(5);
        // R11
        chk(ser_oe == 1'b0, "R11 oe in reset", ser_oe, 0);
        chk(conv_cfg == 8'h00, "R11 cfg in reset", conv_cfg, 0);
        chk(int_mode == 1'b0, "R11 mode in reset", int_mode, 0);
        chk(conv_start == 1'b0, "R11 start in reset", conv_start, 0);
        rst_n = 1'b1;
        wclk(3);
        sel_n = 1'b0;
        wclk(5);
        chk(ser_oe == 1'b1, "R2 oe when selected", ser_oe, 1);
        chk(ser_out == 1'b1, "R3 busy at power-up", ser_out, 1);
        chk(int_mode == 1'b0, "R1 external mode at power-up", int_mode, 0);
        wclk(50);
        chk(ser_out == 1'b0, "R4 asleep with select low", ser_out, 0);
        chk(starts == 0, "R4 no start pulse yet", starts, 0);

        // Table of read cycles
        for (int v = 0; v < 4; v++) begin
            sel_n = 1'b0;
            wclk(6);
            chk(ser_out == 1'b0, "R3 ready flag", ser_out, 0);
            read_frame(VECS[v][23:8], VECS[v][7:0]);
            result_in = (v < 3) ? VECS[v+1][23:8] : 16'h0F0F;
            wclk(24);
            chk(ser_out == 1'b1, "R4 still converting", ser_out, 1);
            wclk(20);
            chk(ser_out == 1'b0, "R4 conversion ended", ser_out, 0);
            sel_n = 1'b1;
            wclk(4);
            chk(ser_oe == 1'b0, "R2 oe released", ser_oe, 0);
        end

        // R9: abandon after 10 clocks
        s0 = starts;
        sel_n = 1'b0;
        wclk(6);
        for (int i = 0; i < 10; i++) sck_cycle(1'b1);
        sel_n = 1'b1;
        wclk(6);
        chk(starts == s0, "R9 no start on abandon", starts, s0);
        chk(conv_cfg == VECS[3][7:0], "R9 cfg kept on abandon", conv_cfg, VECS[3][7:0]);
        result_in = 16'hDEAD;
        sel_n = 1'b0;
        wclk(6);
        chk(ser_out == 1'b0, "R9 restart at flag bit", ser_out, 0);
        read_frame(16'h0F0F, 8'h81);
        wclk(50);

        // R5: long idle, then clocks with select high
        s0 = starts;
        wclk(200);
        chk(ser_out == 1'b0 && starts == s0, "R5 stays asleep", {ser_out, 8'(starts - s0)}, 0);
        sel_n = 1'b1;
        wclk(4);
        for (int i = 0; i < 3; i++) sck_cycle(1'b0);
        sel_n = 1'b0;
        wclk(6);
        chk(starts == s0, "R5 no wake with select high", starts, s0);
        chk(ser_out == 1'b0, "R5 still ready at flag bit", ser_out, 0);

        // R1 R10: internal-clock mode detour
        sel_n = 1'b1;
        wclk(4);
        ser_clk = 1'b1;
        wclk(4);
        sel_n = 1'b0;
        wclk(6);
        chk(int_mode == 1'b1, "R1 internal mode detected", int_mode, 1);
        for (int i = 0; i < 30; i++) begin
            ser_clk = 1'b0;
            wclk(6);
            ser_clk = 1'b1;
            wclk(6);
        end
        chk(starts == s0, "R10 no start in internal mode", starts, s0);
        chk(ser_out == 1'b0, "R10 not woken", ser_out, 0);
        sel_n = 1'b1;
        ser_clk = 1'b0;
        wclk(6);
        sel_n = 1'b0;
        wclk(6);
        chk(int_mode == 1'b0, "R1 external mode restored", int_mode, 0);
        read_frame(16'hDEAD, 8'h5A);
        sel_n = 1'b1;
        wclk(60);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule